// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block divides the serial-port input clock to produce the 16x oversampling strobe that both the transmitter and the receiver of a UART consume. The strobe is a single input-clock-wide pulse. Its spacing is set by a 16-bit whole divisor `N` and a 6-bit fraction `F`, which give an average spacing of `N + F/64` input clocks. The effective division of the input clock to the bit rate therefore runs from 16 up to 65535 × 16, and the divisor need not be an integer.

The fraction is realised by stretching. A 6-bit accumulator adds `F` once per tick period. Each time that addition carries out of 6 bits, the next period is one input clock longer than `N`. Each individual spacing is therefore `N` or `N+1`.

Divisor writes are taken up only at a period boundary. At that boundary the accumulator restarts from zero, so the period in progress always finishes with the old setting. The block runs entirely in the UART clock domain. Crossing the divisor values from the bus domain is left to the surrounding logic.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is held, and after reset with `gen_en` low, `os_tick` stays 0.
- R2: When `gen_en` is first sampled high by a rising edge (from the stopped state) with `div_whole = N ≥ 1`, `os_tick` rises on the N-th rising edge after that one.
- R3: Successive ticks are spaced `N` or `N+1` input clocks apart. When `div_frac = 0`, every spacing is exactly `N`.
- R4: After a fresh start, the 64 spacings that follow the first tick add up to exactly `64·N + F`.
- R5: For `N ≥ 2` each tick lasts one input clock. For `N = 1` with `F = 0` the tick is high on every cycle.
- R6: A whole divisor of 0 stops the generator. The period already in progress still ends with its tick, and no tick follows it.
- R7: Driving `gen_en` low forces `os_tick` low from the next edge onward. Re-enabling restarts with the R2 latency.
- R8: A new `div_whole`/`div_frac` is taken up at the next tick boundary, and the running period finishes with the old value. The fractional accumulator is cleared at that boundary, so the first two spacings with the new setting are exactly the new `N`.
- R9: `rst_uart_n` clears `os_tick` asynchronously. Its release is re-timed through two flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_uart | input | 1 | UART input clock |
| rst_uart_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable |
| div_whole | input | 16 | Whole part `N` of the divisor, in input clocks per tick; 0 stops the generator |
| div_frac | input | 6 | Fractional part `F` of the divisor, in units of 1/64 |
| os_tick | output | 1 | One-cycle oversampling strobe |

## Verification
A fault in the down-counter shows up on the very first tick. The latency from enable, or the first spacing, is off by at least one clock. A fault in the fractional accumulator shows only as a wrong count of stretched periods, so it can hide for up to 64 ticks before the summed spacing differs from `64·N + F`. A fault in the held divisor copy, or in the change detection, appears in the two spacings right after a divisor write. Either the old period is cut short, or a stale accumulator value stretches the first new period.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int INT_W_DEF  = 16;
  localparam int FRAC_W_DEF = 6;
  localparam int SYNC_DEF   = 2;

  // Kind of reload done at a period boundary
  typedef enum logic {
    LOAD_KEEP  = 1'b0,   // same divisor: advance accumulator
    LOAD_FRESH = 1'b1    // start or divisor change: clear accumulator
  } load_kind_e;
endpackage

// File: rtl/bfg_rst_sync.sv
module bfg_rst_sync #(
  parameter int STAGES = fbg_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/bfg_divisor_latch.sv
module bfg_divisor_latch
  import fbg_pkg::*;
#(
  parameter int INT_W  = INT_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              idle,
  input  logic [INT_W-1:0]  live_whole,
  input  logic [FRAC_W-1:0] live_frac,
  output logic [INT_W-1:0]  act_whole,
  output logic [FRAC_W-1:0] act_frac,
  output load_kind_e        kind
);
  logic [INT_W-1:0]  whole_q, whole_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              differs;

  always_comb begin
    differs = (live_whole != whole_q) || (live_frac != frac_q);
    kind    = (idle || differs) ? LOAD_FRESH : LOAD_KEEP;
    whole_d = whole_q;
    frac_d  = frac_q;
    if (load) begin
      whole_d = live_whole;
      frac_d  = live_frac;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whole_q <= '0;
      frac_q  <= '0;
    end else begin
      whole_q <= whole_d;
      frac_q  <= frac_d;
    end
  end

  assign act_whole = whole_q;
  assign act_frac  = frac_q;
endmodule

// File: rtl/bfg_frac_accum.sv
module bfg_frac_accum
  import fbg_pkg::*;
#(
  parameter int FRAC_W = FRAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  load_kind_e        kind,
  input  logic [FRAC_W-1:0] step,
  output logic              stretch
);
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, step};
    stretch = (kind == LOAD_KEEP) && sum[FRAC_W];
    acc_d   = acc_q;
    if (load) begin
      if (kind == LOAD_FRESH) acc_d = '0;
      else                    acc_d = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/bfg_period_counter.sv
module bfg_period_counter #(
  parameter int INT_W = fbg_pkg::INT_W_DEF,
  localparam int CNT_W = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INT_W-1:0] live_whole,
  input  logic             stretch,
  output logic             load,
  output logic             idle,
  output logic [CNT_W-1:0] remain,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             last;

  always_comb begin
    idle   = (cnt_q == '0);
    last   = (cnt_q == CNT_W'(1));
    load   = en && (idle || last);
    tick_d = en && last;
    if (!en) begin
      cnt_d = '0;
    end else if (load) begin
      if (live_whole == '0) cnt_d = '0;
      else cnt_d = {1'b0, live_whole} + {{INT_W{1'b0}}, stretch};
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign remain = cnt_q;
  assign tick   = tick_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int INT_W  = INT_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int SYNC_N = SYNC_DEF
) (
  input  logic              clk_uart,
  input  logic              rst_uart_n,
  input  logic              gen_en,
  input  logic [INT_W-1:0]  div_whole,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              os_tick
);
  localparam int CNT_W = INT_W + 1;

  logic              rst_sync_n;
  logic              load, idle, stretch;
  logic [CNT_W-1:0]  remain;
  logic [INT_W-1:0]  act_whole;
  logic [FRAC_W-1:0] act_frac;
  load_kind_e        kind;

  bfg_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk_uart), .rst_in_n(rst_uart_n), .rst_out_n(rst_sync_n)
  );

  bfg_divisor_latch #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk_uart), .rst_n(rst_sync_n), .load(load), .idle(idle),
    .live_whole(div_whole), .live_frac(div_frac),
    .act_whole(act_whole), .act_frac(act_frac), .kind(kind)
  );

  bfg_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk_uart), .rst_n(rst_sync_n), .load(load), .kind(kind),
    .step(act_frac), .stretch(stretch)
  );

  bfg_period_counter #(.INT_W(INT_W)) u_cnt (
    .clk(clk_uart), .rst_n(rst_sync_n), .en(gen_en),
    .live_whole(div_whole), .stretch(stretch), .load(load),
    .idle(idle), .remain(remain), .tick(os_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  localparam int CNT_W = INT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tick,
  input logic [CNT_W-1:0]  remain,
  input logic [INT_W-1:0]  act_whole,
  input logic [FRAC_W-1:0] act_frac
);
  assert_tick_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(en));

  assert_disable_quiets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

  assert_stopped_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (remain == '0) |=> !tick);

  assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && remain >= CNT_W'(2)) |=> !tick);

  assert_divisor_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && remain > CNT_W'(1)) |=> ($stable(act_whole) && $stable(act_frac)));

  assert_period_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0) |-> (remain <= CNT_W'(act_whole) + CNT_W'(1)));
endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk_uart), .rst_n(rst_sync_n), .en(gen_en), .tick(os_tick),
  .remain(remain), .act_whole(act_whole), .act_frac(act_frac)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [15:0] dw;
  logic [5:0]  df;
  logic        tick;
  int          checks = 0;
  int          fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  frac_baud_gen dut (
    .clk_uart(clk), .rst_uart_n(rst_n), .gen_en(en),
    .div_whole(dw), .div_frac(df), .os_tick(tick)
  );

  // {N[37:22], F[21:16], expected sum of 64 spacings = 64N+F [15:0]}
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {16'd1,   6'd0,  16'd64},
    {16'd1,   6'd63, 16'd127},
    {16'd2,   6'd1,  16'd129},
    {16'd3,   6'd32, 16'd224},
    {16'd5,   6'd63, 16'd383},
    {16'd16,  6'd17, 16'd1041},
    {16'd100, 6'd0,  16'd6400},
    {16'd7,   6'd40, 16'd488}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 70000);
  endtask

  task automatic restart(input int n, input int f);
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    dw = 16'(n); df = 6'(f); en = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat, iv, total, n, f, s, seen;
    bit ok;
    rst_n = 1'b0; en = 1'b1; dw = 16'd1; df = 6'd0;
    // R1: no tick while reset is held, even when enabled
    seen = 0;
    repeat (6) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R1", "ticks during reset", seen, 0);
    en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    seen = 0;
    repeat (20) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R1", "ticks while disabled", seen, 0);

    // Table walk: R2 latency, R3 spacing range, R4 average, R5 width
    for (int i = 0; i < NV; i++) begin
      n = int'(VEC[i][37:22]); f = int'(VEC[i][21:16]); s = int'(VEC[i][15:0]);
      restart(n, f);
      wait_tick(lat);
      check(lat == n + 1, "R2", "first tick latency", lat, n + 1);
      total = 0; ok = 1'b1;
      for (int k = 0; k < 64; k++) begin
        wait_tick(iv);
        total += iv;
        if (iv != n && iv != n + 1) ok = 1'b0;
        if (f == 0 && iv != n) ok = 1'b0;
      end
      check(ok, "R3", "spacings within N..N+1", int'(ok), 1);
      check(total == s, "R4", "sum of 64 spacings", total, s);
      if (n >= 2) begin
        @(negedge clk);
        check(!tick, "R5", "tick width", int'(tick), 0);
      end
    end

    // R5: N=1, F=0 gives a tick on every cycle
    restart(1, 0);
    wait_tick(lat);
    seen = 0;
    repeat (10) begin @(negedge clk); if (tick) seen++; end
    check(seen == 10, "R5", "continuous tick for N=1", seen, 10);

    // R2: largest whole divisor
    restart(65535, 0);
    wait_tick(lat);
    check(lat == 65536, "R2", "latency at N=65535", lat, 65536);

    // R8: whole divisor change mid-period
    restart(10, 0);
    wait_tick(lat);
    dw = 16'd4;
    wait_tick(iv); check(iv == 10, "R8", "old period completes", iv, 10);
    wait_tick(iv); check(iv == 4,  "R8", "first new spacing", iv, 4);
    wait_tick(iv); check(iv == 4,  "R8", "second new spacing", iv, 4);

    // R8: fraction change clears the accumulator (it holds 32 at this point)
    restart(5, 32);
    wait_tick(lat);
    df = 6'd63;
    wait_tick(iv); check(iv == 5, "R8", "spacing before uptake", iv, 5);
    wait_tick(iv); check(iv == 5, "R8", "fresh spacing after change", iv, 5);
    wait_tick(iv); check(iv == 5, "R8", "no carry from cleared acc", iv, 5);
    wait_tick(iv); check(iv == 6, "R8", "first stretch after change", iv, 6);

    // R6: whole divisor 0 stops after the current period
    restart(3, 0);
    wait_tick(lat);
    dw = 16'd0;
    wait_tick(iv); check(iv == 3, "R6", "period in progress ends", iv, 3);
    seen = 0;
    repeat (200) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R6", "ticks after zero divisor", seen, 0);
    restart(0, 5);
    seen = 0;
    repeat (100) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R6", "ticks when started with zero", seen, 0);

    // R7: disable silences the output, re-enable restarts
    restart(3, 0);
    wait_tick(lat);
    en = 1'b0;
    seen = 0;
    repeat (50) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R7", "ticks while disabled", seen, 0);
    en = 1'b1;
    wait_tick(lat);
    check(lat == 4, "R7", "latency after re-enable", lat, 4);

    // R9: asynchronous clear of the tick
    restart(1, 0);
    wait_tick(lat);
    rst_n = 1'b0;
    #1;
    check(!tick, "R9", "tick cleared by async reset", int'(tick), 0);
    @(negedge clk); en = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b1;
    wait_tick(lat);
    check(lat == 2, "R9", "restart after reset release", lat, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule